// File: doc/BRIEF.md
# Serial Bridge Control Register Interface

This block receives 16-bit control words over a three-wire serial link (chip select, data, serial clock) and holds the settings for four motor bridges in two 12-bit control registers. Words arrive least-significant bit first into a holding shift register. A separate strobe input copies the holding word into one of the two control registers. The target register is chosen by the top four bits of the word.

The serial inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and the block detects rising edges on the serial clock and on the strobe. If the serial clock keeps toggling after the sixteenth bit, the holding register keeps shifting, so the last sixteen bits received are the ones that count.

While the strobe is held high, the block commits by itself each time a shift completes a sixteen-bit word. The bit counter saturates at sixteen, and it clears whenever chip select is low. Each bridge receives an enable, a direction bit, a 3-bit current-scale code and a decay-mode select as parallel outputs.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset, every enable, direction, current-scale and decay output is 0.
- R2: A word is shifted in LSB first, and a rising strobe edge copies the holding word into the register its address selects. Address 4'b0000 selects the register for bridges 0 and 1.
- R3: Address 4'b0001 in word bits 15:12 selects the register for bridges 2 and 3.
- R4: A committed word whose address is neither 4'b0000 nor 4'b0001 leaves both registers unchanged.
- R5: Serial clock edges beyond the sixteenth keep shifting, so the last sixteen bits received form the word.
- R6: Serial clock edges seen while chip select is low do not alter the holding register.
- R7: Shifting a full word with the strobe low changes no output until a strobe rising edge occurs.
- R8: While the strobe is held high, a word is committed on the shift that brings the bit count to sixteen, and not before. Every further shift in the same select period also commits the latest sixteen bits.
- R9: Field layout of a register word: bit 0 is enable, bit 1 is direction, bits 4:2 are the current code and bit 5 is decay for the lower bridge; bits 11:6 hold the same fields for the upper bridge. Bridge n drives bit n of each 1-bit output vector and bits 3n+2:3n of the current-scale output.
- R10: The bit counter clears while chip select is low, so bits received before a deselect do not count toward an auto-commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_cs | input | 1 | Serial chip select, active high |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, LSB first |
| ser_stb | input | 1 | Commit strobe; rising edge commits, held high auto-commits |
| br_en | output | 4 | Bridge enables, one bit per bridge |
| br_dir | output | 4 | Bridge current direction |
| br_iscale | output | 12 | 3-bit current-scale code per bridge |
| br_mixdec | output | 4 | Decay select per bridge (1 = mixed, 0 = slow) |

## Verification
The hardest case to reach is the auto-commit boundary with the strobe held high. Three things must be shown: the fifteenth bit commits nothing, the sixteenth does, and a deselect in the middle of a word restarts the count. The bench raises the strobe only when the holding register already matches the committed value, so the strobe's own rising edge is harmless. It then feeds partial words around chip-select drops and checks the outputs after every partial stage. A separate scenario toggles the serial clock with chip select low and then strobes, which shows that the holding register kept the earlier word.

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs #(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int FIELD_W = 6,
  parameter int ISC_W   = 3,
  parameter int NBR     = 4,
  parameter logic [ADDR_W-1:0] ADDR_LO = 4'd0,
  parameter logic [ADDR_W-1:0] ADDR_HI = 4'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_cs,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 ser_stb,
  output logic [NBR-1:0]       br_en,
  output logic [NBR-1:0]       br_dir,
  output logic [NBR*ISC_W-1:0] br_iscale,
  output logic [NBR-1:0]       br_mixdec
);
  localparam int REG_W = WORD_W - ADDR_W;
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [2:0] cs_p, ck_p, stb_p;
  logic [1:0] dat_p;
  logic [WORD_W-1:0] shreg, word_nx, cword;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] reg_lo, reg_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_p <= '0; ck_p <= '0; stb_p <= '0; dat_p <= '0;
    end else begin
      cs_p  <= {cs_p[1:0], ser_cs};
      ck_p  <= {ck_p[1:0], ser_clk};
      stb_p <= {stb_p[1:0], ser_stb};
      dat_p <= {dat_p[0], ser_dat};
    end
  end

  wire cs_q     = cs_p[1];
  wire stb_q    = stb_p[1];
  wire ck_rise  = ck_p[1] & ~ck_p[2];
  wire stb_rise = stb_p[1] & ~stb_p[2];
  wire shift_en = ck_rise & cs_q;
  wire auto_fire = shift_en & stb_q & (cnt >= CNT_LAST);
  wire commit   = stb_rise | auto_fire;

  assign word_nx = {dat_p[1], shreg[WORD_W-1:1]};
  assign cword   = stb_rise ? shreg : word_nx;
  wire [ADDR_W-1:0] caddr = cword[WORD_W-1:REG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      if (shift_en) shreg <= word_nx;
      if (!cs_q) cnt <= '0;
      else if (shift_en && cnt != CNT_FULL) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_lo <= '0;
      reg_hi <= '0;
    end else if (commit) begin
      if (caddr == ADDR_LO) reg_lo <= cword[REG_W-1:0];
      if (caddr == ADDR_HI) reg_hi <= cword[REG_W-1:0];
    end
  end

  wire [2*REG_W-1:0] ctl = {reg_hi, reg_lo};

  for (genvar g = 0; g < NBR; g++) begin : g_br
    wire [FIELD_W-1:0] f = ctl[g*FIELD_W +: FIELD_W];
    assign br_en[g]                  = f[0];
    assign br_dir[g]                 = f[1];
    assign br_iscale[g*ISC_W +: ISC_W] = f[ISC_W+1:2];
    assign br_mixdec[g]              = f[FIELD_W-1];
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);
  p_hold_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> $stable(shreg));
  p_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctl));
  p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && caddr != ADDR_LO && caddr != ADDR_HI) |=> $stable(ctl));
  p_stb_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && shreg[WORD_W-1:REG_W] == ADDR_LO) |=> reg_lo == $past(shreg[REG_W-1:0]));
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> cnt == '0);
endmodule

// File: tb/serial_ctl_regs_tb.sv
module serial_ctl_regs_tb;
  logic clk = 0, rst_n = 0;
  logic ser_cs = 0, ser_clk = 0, ser_dat = 0, ser_stb = 0;
  logic [3:0] br_en, br_dir, br_mixdec;
  logic [11:0] br_iscale;
  int n_chk = 0, n_fail = 0;
  logic [11:0] m_lo = '0, m_hi = '0;
  logic [15:0] m_hold = '0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  serial_ctl_regs u_dut (.clk, .rst_n, .ser_cs, .ser_clk, .ser_dat, .ser_stb,
    .br_en, .br_dir, .br_iscale, .br_mixdec);

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_commit(logic [15:0] w);
    if (w[15:12] == 4'd0) m_lo = w[11:0];
    else if (w[15:12] == 4'd1) m_hi = w[11:0];
  endtask

  task automatic check(string req, string what);
    logic [3:0] e_en, e_dir, e_mix;
    logic [11:0] e_is;
    e_en  = {m_hi[6], m_hi[0], m_lo[6], m_lo[0]};
    e_dir = {m_hi[7], m_hi[1], m_lo[7], m_lo[1]};
    e_mix = {m_hi[11], m_hi[5], m_lo[11], m_lo[5]};
    e_is  = {m_hi[10:8], m_hi[4:2], m_lo[10:8], m_lo[4:2]};
    n_chk++;
    if ({br_en, br_dir, br_mixdec, br_iscale} !== {e_en, e_dir, e_mix, e_is}) begin
      n_fail++;
      $display("FAIL %s %s: en=%b dir=%b mix=%b is=%h expected en=%b dir=%b mix=%b is=%h",
        req, what, br_en, br_dir, br_mixdec, br_iscale, e_en, e_dir, e_mix, e_is);
    end
  endtask

  task automatic set_cs(logic v);
    ser_cs = v;
    if (!v) m_cnt = 0;
    wait_clk(4);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = v[i];
      wait_clk(3);
      ser_clk = 1;
      if (ser_cs) begin
        m_hold = {v[i], m_hold[15:1]};
        if (m_cnt < 16) m_cnt++;
        if (ser_stb && m_cnt == 16) model_commit(m_hold);
      end
      wait_clk(3);
      ser_clk = 0;
      wait_clk(3);
    end
    wait_clk(4);
  endtask

  task automatic pulse_stb();
    ser_stb = 1;
    model_commit(m_hold);
    wait_clk(4);
    ser_stb = 0;
    wait_clk(4);
  endtask

  task automatic t_reset();
    check("R1", "reset state");
  endtask

  task automatic t_lo_layout();
    set_cs(1); shift_bits(32'h02B5, 16); set_cs(0);
    check("R7", "no commit without strobe");
    pulse_stb();
    check("R2", "strobe commit to low register");
    n_chk++;
    if (br_en !== 4'b0001 || br_dir !== 4'b0010 || br_iscale !== 12'h015 || br_mixdec !== 4'b0001) begin
      n_fail++;
      $display("FAIL R9 field layout: en=%b dir=%b is=%h mix=%b expected en=0001 dir=0010 is=015 mix=0001",
        br_en, br_dir, br_iscale, br_mixdec);
    end
  endtask

  task automatic t_hi();
    set_cs(1); shift_bits(32'h1ABC, 16); set_cs(0);
    pulse_stb();
    check("R3", "commit to high register");
  endtask

  task automatic t_bad_addr();
    set_cs(1); shift_bits(32'h5FFF, 16); set_cs(0);
    pulse_stb();
    check("R4", "address 5 discarded");
    set_cs(1); shift_bits(32'hF123, 16); set_cs(0);
    pulse_stb();
    check("R4", "address F discarded");
  endtask

  task automatic t_extra_clocks();
    set_cs(1); shift_bits(32'h0C3A5, 20); set_cs(0);
    pulse_stb();
    check("R5", "last sixteen bits win");
  endtask

  task automatic t_cs_gate();
    set_cs(1); shift_bits(32'h1555, 16); set_cs(0);
    shift_bits(32'h0FFF, 16);
    pulse_stb();
    check("R6", "clocks with cs low ignored");
  endtask

  task automatic t_auto();
    ser_stb = 1;
    model_commit(m_hold);
    wait_clk(4);
    set_cs(1);
    shift_bits(32'h0777, 15);
    check("R8", "no auto commit after fifteen bits");
    shift_bits(32'h0, 1);
    check("R8", "auto commit on sixteenth bit");
    set_cs(0);
  endtask

  task automatic t_cnt_clear();
    set_cs(1); shift_bits(32'h3FF, 10); set_cs(0);
    set_cs(1); shift_bits(32'h2A, 8);
    check("R10", "count restarted after deselect");
    shift_bits(32'h1D, 8);
    check("R10", "auto commit after sixteen fresh bits");
    shift_bits(32'h3, 2);
    check("R8", "extra shifts auto commit latest word");
    set_cs(0);
    ser_stb = 0;
    wait_clk(4);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    wait_clk(5);
    rst_n = 1;
    wait_clk(3);
    t_reset();
    t_lo_layout();
    t_hi();
    t_bad_addr();
    t_extra_clocks();
    t_cs_gate();
    t_auto();
    t_cnt_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule